// File: doc/BRIEF.md
# Stoppable Clock Divider and Output Parking Controller

The block derives a family of system clocks from one fast master clock by integer division: two CPU clocks, four stoppable PCI clocks, one free-running PCI clock, a fixed clock near 48 MHz and an auxiliary clock that runs at either the fixed rate or half of it. With the default 200 MHz master clock, the CPU clocks divide by 2 (100 MHz) or by 3 (66.6 MHz), and every PCI clock divides by 6 (33.3 MHz) whatever the CPU rate. One shared phase counter drives the CPU and PCI dividers, so their edges stay locked. The PCI outputs are delayed by one master cycle, so each PCI rising edge comes just after a CPU rising edge.

Three active-low control inputs can stop outputs at any time, with no timing relation to the output clocks: a CPU stop, a PCI stop and a power-down. Each one passes through a two-flop synchronizer. Each output keeps its own gate enable, and that enable changes only at the start of a divider cycle. A stopped output therefore finishes its current cycle and then stays low. A released output waits for the next cycle boundary and restarts with a complete high phase. The CPU speed select and the auxiliary rate select are captured once, in the first master cycle after reset. The outputs are plain clock levels and there is no handshake at the block's edge.

Top module: `clkstop_gen`

## Requirements
- R1: While reset is asserted, every output is low.
- R2: With the captured speed select at 1, each CPU output repeats every 2 master cycles and is high for 1 of them. With it at 0, each CPU output repeats every 3 master cycles and is high for 2 of them. Both CPU outputs are always equal.
- R3: The four stoppable PCI outputs and the free-running PCI output each repeat every 6 master cycles and are high for 3, at either CPU speed.
- R4: The fixed output repeats every 4 master cycles and is high for 2. The auxiliary output repeats every 8 master cycles with 4 high when the captured rate select is 1, and matches the fixed output's timing when it is 0.
- R5: Both selects are sampled in the first master cycle after reset is released. Later changes to either pin have no effect on any output period until the next reset.
- R6: Once the CPU stop has been low for a little over 2 synchronizer cycles plus one CPU period, both CPU outputs stay low. All PCI, fixed and auxiliary outputs keep running.
- R7: Once the PCI stop has been held low long enough, the four stoppable PCI outputs stay low. The free-running PCI output and the CPU outputs keep running.
- R8: Once the power-down input has been held low long enough, all nine outputs stay low.
- R9: No output ever produces a shortened high pulse, including when it is stopped or resumed. Each rising edge of an output falls a whole number of its own periods after its previous rising edge.
- R10: While the CPU outputs are running, every PCI rising edge comes exactly 1 master cycle after a CPU rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Fast master clock (200 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_fast_sel | input | 1 | CPU speed select: 1 selects divide-by-2, 0 selects divide-by-3; captured after reset |
| half_rate_sel | input | 1 | Auxiliary rate select: 1 selects half the fixed rate; captured after reset |
| cpu_halt_n | input | 1 | Asynchronous active-low CPU stop request |
| pci_halt_n | input | 1 | Asynchronous active-low PCI stop request |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_clk | output | N_CPU (2) | CPU clock outputs |
| pci_clk | output | N_PCI (4) | Stoppable PCI clock outputs |
| pci_free_clk | output | 1 | Free-running PCI clock output, unaffected by the PCI stop |
| fix_clk | output | 1 | Fixed-rate clock output |
| aux_clk | output | 1 | Auxiliary clock output, fixed rate or half of it |

## Verification
A corrupted phase counter or divider state shows up at once as a rising edge off its divider grid, or as a high pulse of the wrong length. Either is detected at the next edge of the affected output, within 8 master cycles. A gate enable that is updated away from a cycle boundary produces a runt pulse or a misplaced restart on the first stop or release that follows. A wrong captured select changes the measured rise count within one 24-cycle window. A stuck synchronizer leaves an output toggling, or parked, after the settling time, and this is visible in the first stop window.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Position of one divider inside its cycle for the next master cycle.
  typedef struct packed {
    logic start;  // next master cycle begins a new output cycle
    logic hi;     // output level wanted in the next master cycle
  } tap_t;

  function automatic tap_t make_tap(logic [31:0] pos, logic [31:0] div);
    tap_t t;
    logic [31:0] slot;
    slot    = pos % div;
    t.start = (slot == 32'd0);
    t.hi    = (slot < ((div + 32'd1) >> 1));
    return t;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Reset to "running" so outputs start once the straps are captured.
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
  parameter int PERIOD = 6,
  localparam int PW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] ph,
  output logic [PW-1:0] ph_nx
);
  logic [PW-1:0] wrap;

  always_comb begin
    wrap  = (ph == PW'(PERIOD - 1)) ? '0 : ph + 1'b1;
    ph_nx = step ? wrap : ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_nx;
  end
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
#(
  parameter int LAG = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  tap_t tap,
  input  logic req,
  output logic clk_o
);
  logic en;
  logic lvl;
  logic en_use;

  // The gate enable only moves at a cycle start, while the output is low.
  assign en_use = tap.start ? req : en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      lvl <= 1'b0;
    end else if (step) begin
      en  <= en_use;
      lvl <= tap.hi & en_use;
    end
  end

  generate
    if (LAG == 0) begin : g_direct
      assign clk_o = lvl;
    end else begin : g_delay
      logic [LAG-1:0] dly;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly <= '0;
        end else begin
          dly[0] <= lvl;
          for (int k = 1; k < LAG; k++) dly[k] <= dly[k-1];
        end
      end
      assign clk_o = dly[LAG-1];
    end
  endgenerate
endmodule

// File: rtl/clkstop_gen.sv
module clkstop_gen
  import clkstop_pkg::*;
#(
  parameter int N_CPU        = 2,
  parameter int N_PCI        = 4,
  parameter int CPU_DIV_FAST = 2,
  parameter int CPU_DIV_SLOW = 3,
  parameter int PCI_DIV      = 6,
  parameter int FIX_DIV      = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int PCI_LAG      = 1
) (
  input  logic             clk_master,
  input  logic             rst_n,
  input  logic             cpu_fast_sel,
  input  logic             half_rate_sel,
  input  logic             cpu_halt_n,
  input  logic             pci_halt_n,
  input  logic             pwr_dn_n,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_free_clk,
  output logic             fix_clk,
  output logic             aux_clk
);
  localparam int PA  = PCI_DIV;
  localparam int PB  = 2 * FIX_DIV;
  localparam int PWA = (PA > 1) ? $clog2(PA) : 1;
  localparam int PWB = (PB > 1) ? $clog2(PB) : 1;

  // Straps captured once after reset.
  logic armed, fast_q, half_q;
  always_ff @(posedge clk_master or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      fast_q <= 1'b0;
      half_q <= 1'b0;
    end else if (!armed) begin
      armed  <= 1'b1;
      fast_q <= cpu_fast_sel;
      half_q <= half_rate_sel;
    end
  end

  // Request synchronizers.
  logic [2:0] req_s;
  clkstop_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_master),
    .rst_n (rst_n),
    .d     ({pwr_dn_n, pci_halt_n, cpu_halt_n}),
    .q     (req_s)
  );

  logic cpu_run_s, pci_run_s, pwr_on_s;
  assign cpu_run_s = req_s[0];
  assign pci_run_s = req_s[1];
  assign pwr_on_s  = req_s[2];

  logic cpu_req, pci_req;
  assign cpu_req = cpu_run_s & pwr_on_s;
  assign pci_req = pci_run_s & pwr_on_s;

  // Shared phase references.
  logic [PWA-1:0] ph_a, ph_a_nx;
  logic [PWB-1:0] ph_b, ph_b_nx;

  clkstop_phase #(.PERIOD(PA)) u_ph_a (
    .clk   (clk_master),
    .rst_n (rst_n),
    .step  (armed),
    .ph    (ph_a),
    .ph_nx (ph_a_nx)
  );

  clkstop_phase #(.PERIOD(PB)) u_ph_b (
    .clk   (clk_master),
    .rst_n (rst_n),
    .step  (armed),
    .ph    (ph_b),
    .ph_nx (ph_b_nx)
  );

  // Divider taps.
  logic [31:0] cpu_div, aux_div;
  assign cpu_div = fast_q ? 32'(CPU_DIV_FAST) : 32'(CPU_DIV_SLOW);
  assign aux_div = half_q ? 32'(PB) : 32'(FIX_DIV);

  tap_t cpu_tap, pci_tap, fix_tap, aux_tap;
  assign cpu_tap = make_tap(32'(ph_a_nx), cpu_div);
  assign pci_tap = make_tap(32'(ph_a_nx), 32'(PCI_DIV));
  assign fix_tap = make_tap(32'(ph_b_nx), 32'(FIX_DIV));
  assign aux_tap = make_tap(32'(ph_b_nx), aux_div);

  // Output lanes.
  generate
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      clkstop_lane #(.LAG(0)) u_lane (
        .clk   (clk_master),
        .rst_n (rst_n),
        .step  (armed),
        .tap   (cpu_tap),
        .req   (cpu_req),
        .clk_o (cpu_clk[c])
      );
    end
    for (genvar p = 0; p < N_PCI; p++) begin : g_pci
      clkstop_lane #(.LAG(PCI_LAG)) u_lane (
        .clk   (clk_master),
        .rst_n (rst_n),
        .step  (armed),
        .tap   (pci_tap),
        .req   (pci_req),
        .clk_o (pci_clk[p])
      );
    end
  endgenerate

  clkstop_lane #(.LAG(PCI_LAG)) u_free (
    .clk   (clk_master),
    .rst_n (rst_n),
    .step  (armed),
    .tap   (pci_tap),
    .req   (pwr_on_s),
    .clk_o (pci_free_clk)
  );

  clkstop_lane #(.LAG(0)) u_fix (
    .clk   (clk_master),
    .rst_n (rst_n),
    .step  (armed),
    .tap   (fix_tap),
    .req   (pwr_on_s),
    .clk_o (fix_clk)
  );

  clkstop_lane #(.LAG(0)) u_aux (
    .clk   (clk_master),
    .rst_n (rst_n),
    .step  (armed),
    .tap   (aux_tap),
    .req   (pwr_on_s),
    .clk_o (aux_clk)
  );

  logic unused_ph_b;
  assign unused_ph_b = ^ph_b;
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int N_CPU        = 2,
  parameter int N_PCI        = 4,
  parameter int CPU_DIV_FAST = 2,
  parameter int CPU_DIV_SLOW = 3,
  parameter int PCI_DIV      = 6,
  parameter int FIX_DIV      = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int PCI_LAG      = 1,
  parameter int PWA          = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_halt_n,
  input logic             pci_halt_n,
  input logic             pwr_dn_n,
  input logic [N_CPU-1:0] cpu_clk,
  input logic [N_PCI-1:0] pci_clk,
  input logic             pci_free_clk,
  input logic             fix_clk,
  input logic             aux_clk,
  input logic             armed,
  input logic             fast_q,
  input logic             half_q,
  input logic [PWA-1:0]   ph_a
);
  localparam int LIMIT = SYNC_STAGES + 4 * FIX_DIV + PCI_LAG + 2;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] n_cpu, n_pci, n_pd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cpu <= '0;
      n_pci <= '0;
      n_pd  <= '0;
    end else begin
      n_cpu <= cpu_halt_n ? '0 : ((n_cpu == CW'(LIMIT)) ? n_cpu : n_cpu + 1'b1);
      n_pci <= pci_halt_n ? '0 : ((n_pci == CW'(LIMIT)) ? n_pci : n_pci + 1'b1);
      n_pd  <= pwr_dn_n   ? '0 : ((n_pd  == CW'(LIMIT)) ? n_pd  : n_pd  + 1'b1);
    end
  end

  // R2: CPU rising edges sit on the CPU divider grid of the shared phase
  a_r2_cpu_grid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk[0]) |-> ((32'(ph_a) % (fast_q ? 32'(CPU_DIV_FAST) : 32'(CPU_DIV_SLOW))) == 32'd0));

  // R2: CPU outputs stay identical
  a_r2_cpu_pair: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk == {N_CPU{cpu_clk[0]}});

  // R10: PCI rises PCI_LAG cycles after the phase origin
  a_r10_pci_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_free_clk) |-> (32'(ph_a) == 32'(PCI_LAG % PCI_DIV)));

  // R5: straps do not move once captured
  a_r5_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (armed && $stable(fast_q) && $stable(half_q)));

  // R6: long CPU stop parks the CPU outputs
  a_r6_cpu_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (n_cpu == CW'(LIMIT)) |-> (cpu_clk == '0));

  // R7: long PCI stop parks the stoppable PCI outputs
  a_r7_pci_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (n_pci == CW'(LIMIT)) |-> (pci_clk == '0));

  // R8: long power-down parks everything
  a_r8_all_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (n_pd == CW'(LIMIT)) |-> ({cpu_clk, pci_clk, pci_free_clk, fix_clk, aux_clk} == '0));
endmodule

bind clkstop_gen clkstop_chk #(
  .N_CPU        (N_CPU),
  .N_PCI        (N_PCI),
  .CPU_DIV_FAST (CPU_DIV_FAST),
  .CPU_DIV_SLOW (CPU_DIV_SLOW),
  .PCI_DIV      (PCI_DIV),
  .FIX_DIV      (FIX_DIV),
  .SYNC_STAGES  (SYNC_STAGES),
  .PCI_LAG      (PCI_LAG),
  .PWA          ((PCI_DIV > 1) ? $clog2(PCI_DIV) : 1)
) u_chk (
  .clk          (clk_master),
  .rst_n        (rst_n),
  .cpu_halt_n   (cpu_halt_n),
  .pci_halt_n   (pci_halt_n),
  .pwr_dn_n     (pwr_dn_n),
  .cpu_clk      (cpu_clk),
  .pci_clk      (pci_clk),
  .pci_free_clk (pci_free_clk),
  .fix_clk      (fix_clk),
  .aux_clk      (aux_clk),
  .armed        (armed),
  .fast_q       (fast_q),
  .half_q       (half_q),
  .ph_a         (ph_a)
);

// File: tb/test_clkstop_gen.sv
module test_clkstop_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT       = 9;
  localparam int NONE       = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_sel = 1'b1, half_sel = 1'b0;
  logic cpu_halt_n = 1'b1, pci_halt_n = 1'b1, pwr_dn_n = 1'b1;
  logic [1:0] cpu_clk;
  logic [3:0] pci_clk;
  logic pci_free_clk, fix_clk, aux_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkstop_gen i_clkstop_gen (
    .clk_master    (clk),
    .rst_n         (rst_n),
    .cpu_fast_sel  (fast_sel),
    .half_rate_sel (half_sel),
    .cpu_halt_n    (cpu_halt_n),
    .pci_halt_n    (pci_halt_n),
    .pwr_dn_n      (pwr_dn_n),
    .cpu_clk       (cpu_clk),
    .pci_clk       (pci_clk),
    .pci_free_clk  (pci_free_clk),
    .fix_clk       (fix_clk),
    .aux_clk       (aux_clk)
  );

  // bit map: [1:0] cpu, [5:2] pci, [6] free pci, [7] fixed, [8] aux
  wire [NOUT-1:0] obs = {aux_clk, fix_clk, pci_free_clk, pci_clk, cpu_clk};

  int n_vec = 0, n_bad = 0;
  logic exp_fast = 1'b1, exp_half = 1'b0;
  logic mon_on = 1'b0;
  bit done = 1'b0;

  function automatic int exp_per(int i);
    if (i < 2) return exp_fast ? 2 : 3;
    if (i < 7) return 6;
    if (i == 7) return 4;
    return exp_half ? 8 : 4;
  endfunction

  function automatic int exp_hi(int i);
    return (exp_per(i) + 1) / 2;
  endfunction

  function automatic string per_tag(int i);
    if (i < 2) return "R2";
    if (i < 7) return "R3";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Continuous monitor: pulse widths, rise grid, CPU-to-PCI lag.
  int   since [NOUT];
  int   hirun [NOUT];
  logic prev  [NOUT];
  logic track [NOUT];

  always @(negedge clk) begin
    if (!mon_on) begin
      for (int i = 0; i < NOUT; i++) begin
        since[i] = NONE; hirun[i] = 0; prev[i] = obs[i]; track[i] = 1'b0;
      end
    end else begin
      if (obs[6] && !prev[6] && since[0] < exp_per(0))
        check(since[0] == 0, "R10 cpu-to-pci lag", since[0] + 1, 1);
      for (int i = 0; i < NOUT; i++) begin
        if (obs[i] && !prev[i]) begin
          if (since[i] < NONE)
            check(((since[i] + 1) % exp_per(i)) == 0, "R9 rise grid", since[i] + 1, exp_per(i));
          since[i] = 0;
          hirun[i] = 1;
          track[i] = 1'b1;
        end else begin
          if (since[i] < NONE) since[i]++;
          if (obs[i]) hirun[i]++;
        end
        if (!obs[i] && prev[i] && track[i]) begin
          check(hirun[i] == exp_hi(i), "R9 high width", hirun[i], exp_hi(i));
          check(hirun[i] == exp_hi(i), per_tag(i), hirun[i], exp_hi(i));
        end
        prev[i] = obs[i];
      end
    end
  end

  // Window measurement.
  int win_rises [NOUT];
  logic [NOUT-1:0] win_hi;

  task automatic window(int n);
    logic [NOUT-1:0] wp;
    wp = obs;
    win_hi = '0;
    for (int i = 0; i < NOUT; i++) win_rises[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < NOUT; i++) if (obs[i] && !wp[i]) win_rises[i]++;
      win_hi |= obs;
      wp = obs;
    end
  endtask

  task automatic check_rates(string req);
    window(24);
    for (int i = 0; i < NOUT; i++)
      check(win_rises[i] == 24 / exp_per(i), req, win_rises[i], 24 / exp_per(i));
  endtask

  task automatic do_reset(logic f, logic h);
    @(negedge clk);
    rst_n = 1'b0; mon_on = 1'b0;
    fast_sel = f; half_sel = h;
    repeat (3) @(negedge clk);
    check(obs == '0, "R1 reset low", int'(obs), 0);
    rst_n = 1'b1;
    exp_fast = f; exp_half = h;
    mon_on = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c1c_5eed));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R3 R4: fast CPU, aux at fixed rate
    do_reset(1'b1, 1'b0);
    check_rates("R2/R3/R4 rates fast");

    // R5: pin changes after reset do nothing
    fast_sel = 1'b0; half_sel = 1'b1;
    repeat (10) @(negedge clk);
    check_rates("R5 straps held");

    // slow CPU, half-rate aux
    do_reset(1'b0, 1'b1);
    check_rates("R2/R4 rates slow");

    // R6: CPU stop
    cpu_halt_n = 1'b0;
    repeat (24) @(negedge clk);
    window(24);
    check(win_hi[1:0] == 2'b00, "R6 cpu parked", int'(win_hi[1:0]), 0);
    for (int i = 2; i < NOUT; i++)
      check(win_rises[i] == 24 / exp_per(i), "R6 others run", win_rises[i], 24 / exp_per(i));
    cpu_halt_n = 1'b1;
    repeat (24) @(negedge clk);
    check_rates("R9 resume after cpu stop");

    // R7: PCI stop
    pci_halt_n = 1'b0;
    repeat (24) @(negedge clk);
    window(24);
    check(win_hi[5:2] == 4'b0000, "R7 pci parked", int'(win_hi[5:2]), 0);
    check(win_rises[6] == 4, "R7 free pci runs", win_rises[6], 4);
    check(win_rises[0] == 24 / exp_per(0), "R7 cpu runs", win_rises[0], 24 / exp_per(0));
    pci_halt_n = 1'b1;
    repeat (24) @(negedge clk);

    // R8: power-down
    pwr_dn_n = 1'b0;
    repeat (24) @(negedge clk);
    window(24);
    check(win_hi == '0, "R8 all parked", int'(win_hi), 0);
    pwr_dn_n = 1'b1;
    repeat (24) @(negedge clk);
    check_rates("R8 resume after power-down");

    // Random stop traffic, monitor checks R9 and R10 throughout.
    for (int r = 0; r < 3; r++) begin
      do_reset(1'($urandom % 2), 1'($urandom % 2));
      for (int s = 0; s < 250; s++) begin
        cpu_halt_n = ($urandom % 4) != 0;
        pci_halt_n = ($urandom % 4) != 0;
        pwr_dn_n   = ($urandom % 8) != 0;
        if ($urandom % 16 == 0) fast_sel = ~fast_sel;
        if ($urandom % 16 == 0) half_sel = ~half_sel;
        repeat (1 + $urandom % 30) @(negedge clk);
      end
      cpu_halt_n = 1'b1; pci_halt_n = 1'b1; pwr_dn_n = 1'b1;
      repeat (30) @(negedge clk);
      check_rates("R5 rates after random traffic");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule